// File: doc/BRIEF.md
# Cartridge ROM Block-Read Controller

This controller sits between a host processor and the ROM of a plug-in cartridge. Software first writes an eight-byte command, one byte per write, into the command slots. It then writes the control word with its start bit set. A data-read command (slot 0 = 0xB7) takes a start address from slots 1 to 4 and fetches a block of 32-bit words from a ROM read port. Each fetch waits a timed delay, so the host sees words arriving at the pace of a real card. An identify command (slot 0 = 0xB8) makes a fixed chip identifier word available at once.

Each fetched word is held in a data register and flagged by `word_ready`. When the host strobes `host_rd`, the flag clears and the next fetch is timed from that strobe. When the last word of the block arrives, an interrupt pulse can be raised. A one-cycle DMA request pulse can accompany every arriving word. Time is measured in byte-times of 5 or 8 clocks, and a byte-time doubles when the slower bus master owns the slot.

Top module: `cart_rom_reader`

## Requirements
- R1: For command 0xB7 the start address is {slot1, slot2, slot3, slot4}, with slot 1 as the most significant byte. Successive words come from that address, then address+4, and so on.
- R2: A requested address below 0x8000 is replaced by 0x8000 plus bits [8:0] of the requested address.
- R3: Block field values 1 to 6 give a block of 0x100 << field bytes, that is (0x100 << field)/4 words. Values 0 and 7 give no block: no fetch starts, and `busy` stays high until a control write with start = 0.
- R4: The first fetch request rises (delay + 12) byte-times after the clock edge that takes the start.
- R5: A byte-time is 8 clocks when `ctl_fast` was 1 at start and 5 clocks otherwise. It is doubled while `slow_owner` is 1.
- R6: When the ROM acknowledges a request, the word appears on `host_rdata` and `word_ready` is high from the next cycle on.
- R7: After reset, `busy`, `word_ready`, `irq` and `rom_req` are low. A `host_rd` strobe clears `word_ready`. If words remain, the next request rises 4 byte-times after the strobe edge. Otherwise `busy` falls.
- R8: When the last word of a block arrives and `irq_en` is 1, `irq` pulses for one cycle. It pulses at no other time.
- R9: Command 0xB8 makes `CHIP_ID` readable with `word_ready` and `busy` high in the cycle after the start edge. It issues no ROM request, and a single read ends it.
- R10: Control writes made while `spi_mode` is 1 are ignored.
- R11: Any slot-0 code other than 0xB7 or 0xB8 issues no request and keeps `word_ready` low. `busy` stays high until a control write with start = 0.
- R12: A start taken while a transfer is in progress discards the old timer and times the first fetch from the new start.
- R13: When `dma_en` is 1, `dma_req` pulses once for each arriving word. When `dma_en` is 0, it never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Write strobe for one command slot |
| cmd_idx | input | 3 | Command slot index |
| cmd_byte | input | 8 | Command slot data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_start | input | 1 | Control start bit: 1 starts, 0 stops |
| ctl_fast | input | 1 | Rate select: 1 = 8-clock byte-time |
| ctl_blk | input | 3 | Block size field |
| ctl_delay | input | DELAY_W | Initial delay in byte-times, before the fixed 12 are added |
| spi_mode | input | 1 | Auxiliary port is in serial mode |
| irq_en | input | 1 | Completion interrupt enable |
| dma_en | input | 1 | DMA request enable |
| slow_owner | input | 1 | Slot owned by the slower bus master |
| host_rd | input | 1 | Host read strobe for the data register |
| host_rdata | output | 32 | Data register |
| word_ready | output | 1 | Data register holds an unread word |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Transfer-complete pulse |
| dma_req | output | 1 | Per-word DMA request pulse |
| rom_req | output | 1 | ROM word-read request, held until acknowledged |
| rom_addr | output | 32 | ROM byte address of the requested word |
| rom_ack | input | 1 | ROM response valid |
| rom_data | input | 32 | ROM response word |

## Verification
The assertions assume three things about the inputs. `rom_ack` is raised only while `rom_req` is high. The host strobes `host_rd` only while no fetch is outstanding. No control write coincides with a ROM acknowledge. The bench keeps within these limits in three ways. Its ROM model answers exactly one cycle after it sees a request. Its host model reads only while `word_ready` is high. Control writes for a new start are issued only while the design is idle or still counting down before a fetch.

// File: rtl/cart_rom_reader.sv
module cart_rom_reader #(
  parameter int DELAY_W = 13,
  parameter logic [31:0] CHIP_ID = 32'h1FC2_00A5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [2:0]         cmd_idx,
  input  logic [7:0]         cmd_byte,
  input  logic               ctl_we,
  input  logic               ctl_start,
  input  logic               ctl_fast,
  input  logic [2:0]         ctl_blk,
  input  logic [DELAY_W-1:0] ctl_delay,
  input  logic               spi_mode,
  input  logic               irq_en,
  input  logic               dma_en,
  input  logic               slow_owner,
  input  logic               host_rd,
  output logic [31:0]        host_rdata,
  output logic               word_ready,
  output logic               busy,
  output logic               irq,
  output logic               dma_req,
  output logic               rom_req,
  output logic [31:0]        rom_addr,
  input  logic               rom_ack,
  input  logic [31:0]        rom_data
);
  localparam int CNT_W = DELAY_W + 5;
  localparam int LEN_W = 15;
  localparam logic [7:0] OP_READ = 8'hB7;
  localparam logic [7:0] OP_ID   = 8'hB8;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_FETCH} st_t;

  st_t              st_q;
  logic [7:0]       cmd_q [8];
  logic [31:0]      addr_q, buf_q;
  logic [LEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fast_q, busy_q, ready_q, irq_q, dma_q;

  function automatic logic [CNT_W-1:0] byte_clocks(input logic [DELAY_W:0] n,
                                                   input logic fast, input logic slow);
    logic [CNT_W-1:0] u;
    u = fast ? CNT_W'(8) : CNT_W'(5);
    if (slow) u = u << 1;
    return CNT_W'(n) * u;
  endfunction

  wire              ctl_take = ctl_we && !spi_mode;
  wire [31:0]       req_addr = {cmd_q[1], cmd_q[2], cmd_q[3], cmd_q[4]};
  wire [31:0]       eff_addr = (req_addr < 32'h8000) ? {16'h0, 1'b1, 6'h0, req_addr[8:0]} : req_addr;
  wire [LEN_W-1:0]  blk_len  = (ctl_blk == 3'd0 || ctl_blk == 3'd7) ? '0 : (LEN_W'(256) << ctl_blk);
  wire [DELAY_W:0]  first_n  = {1'b0, ctl_delay} + (DELAY_W+1)'(12);
  wire              got_word = (st_q == S_FETCH) && rom_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      for (int i = 0; i < 8; i++) cmd_q[i] <= '0;
      addr_q <= '0; buf_q <= '0; rem_q <= '0; cnt_q <= '0;
      fast_q <= 1'b0; busy_q <= 1'b0; ready_q <= 1'b0; irq_q <= 1'b0; dma_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      dma_q <= 1'b0;
      if (cmd_we) cmd_q[cmd_idx] <= cmd_byte;
      if (ctl_take) begin
        st_q    <= S_IDLE;
        rem_q   <= '0;
        ready_q <= 1'b0;
        busy_q  <= ctl_start;
        if (ctl_start) begin
          fast_q <= ctl_fast;
          if (cmd_q[0] == OP_READ && blk_len != '0) begin
            addr_q <= eff_addr;
            rem_q  <= blk_len;
            cnt_q  <= byte_clocks(first_n, ctl_fast, slow_owner);
            st_q   <= S_WAIT;
          end else if (cmd_q[0] == OP_ID) begin
            buf_q   <= CHIP_ID;
            ready_q <= 1'b1;
          end
        end
      end else begin
        case (st_q)
          S_WAIT: begin
            if (cnt_q <= CNT_W'(1)) st_q <= S_FETCH;
            else cnt_q <= cnt_q - 1'b1;
          end
          S_FETCH: begin
            if (rom_ack) begin
              buf_q   <= rom_data;
              addr_q  <= addr_q + 32'd4;
              rem_q   <= rem_q - LEN_W'(4);
              ready_q <= 1'b1;
              dma_q   <= dma_en;
              irq_q   <= irq_en && (rem_q == LEN_W'(4));
              st_q    <= S_IDLE;
            end
          end
          default: ;
        endcase
        if (host_rd && st_q != S_FETCH) begin
          ready_q <= 1'b0;
          if (rem_q != '0) begin
            cnt_q <= byte_clocks((DELAY_W+1)'(4), fast_q, slow_owner);
            st_q  <= S_WAIT;
          end else begin
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  assign host_rdata = buf_q;
  assign word_ready = ready_q;
  assign busy       = busy_q;
  assign irq        = irq_q;
  assign dma_req    = dma_q;
  assign rom_req    = (st_q == S_FETCH);
  assign rom_addr   = addr_q;

  // R6
  ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (got_word && !ctl_take) |=> word_ready);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && !rom_ack && !ctl_take) |=> rom_req);
  // R7
  read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !rom_req && !ctl_take) |=> !word_ready);
  // R8
  irq_on_last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (word_ready && busy && !rom_req));
  // R13
  dma_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> word_ready);
  // R10
  spi_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_mode && ctl_we && !host_rd) |=> $stable(busy));
  // R9
  id_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_take && ctl_start && cmd_q[0] == OP_ID) |=> (word_ready && busy && !rom_req));
endmodule

// File: tb/tb_cart_rom_reader.sv
module tb_cart_rom_reader;
  localparam int DW = 13;
  localparam logic [31:0] ID = 32'h1FC2_00A5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, ctl_we = 0, ctl_start = 0, ctl_fast = 0;
  logic [2:0] cmd_idx = 0, ctl_blk = 0;
  logic [7:0] cmd_byte = 0;
  logic [DW-1:0] ctl_delay = 0;
  logic spi_mode = 0, irq_en = 0, dma_en = 0, slow_owner = 0, host_rd = 0;
  logic rom_ack = 0;
  logic [31:0] rom_data = 0;
  logic [31:0] host_rdata, rom_addr;
  logic word_ready, busy, irq, dma_req, rom_req;

  cart_rom_reader #(.DELAY_W(DW), .CHIP_ID(ID)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_idx(cmd_idx), .cmd_byte(cmd_byte),
    .ctl_we(ctl_we), .ctl_start(ctl_start), .ctl_fast(ctl_fast), .ctl_blk(ctl_blk),
    .ctl_delay(ctl_delay), .spi_mode(spi_mode), .irq_en(irq_en), .dma_en(dma_en),
    .slow_owner(slow_owner), .host_rd(host_rd), .host_rdata(host_rdata),
    .word_ready(word_ready), .busy(busy), .irq(irq), .dma_req(dma_req),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack), .rom_data(rom_data));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, t_ref = 0, exp_gap = 0, req_cnt = 0, irq_cnt = 0, dma_cnt = 0, words = 0;
  bit gap_on = 0, req_prev = 0, chk_clear = 0, fast_cur = 0, done = 0;
  string gap_tag = "R4", data_tag = "R1";
  logic [31:0] exp_q[$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[7:0], a[31:8]} ^ 32'hA53C_0F96;
  endfunction

  function automatic int unit_clk(input bit f);
    int u;
    u = f ? 8 : 5;
    if (slow_owner) u = u * 2;
    return u;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // ROM model: answers one cycle after a request is seen
  initial forever begin
    @(negedge clk);
    rom_ack  = rom_req;
    rom_data = pat(rom_addr);
  end

  // monitor: host reads, scoreboard compare, timing and pulse counting
  initial forever begin
    @(negedge clk);
    if (rom_req && !req_prev) begin
      req_cnt++;
      if (gap_on) check(cyc - t_ref == exp_gap, gap_tag, cyc - t_ref, exp_gap);
      gap_on = 0;
    end
    req_prev = rom_req;
    if (irq) irq_cnt++;
    if (dma_req) dma_cnt++;
    if (chk_clear) begin
      check(!word_ready, "R7 ready clear", word_ready, 0);
      chk_clear = 0;
    end
    if (host_rd) host_rd = 0;
    else if (word_ready && exp_q.size() > 0) begin
      logic [31:0] d;
      d = exp_q.pop_front();
      check(host_rdata == d, data_tag, host_rdata, d);
      words++;
      host_rd = 1;
      t_ref = cyc + 1;
      exp_gap = 4 * unit_clk(fast_cur);
      gap_tag = "R7 next gap";
      gap_on = (exp_q.size() > 0);
      chk_clear = 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  task automatic put_cmd(input logic [7:0] op, input logic [31:0] a);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cmd_we = 1; cmd_idx = 3'(i);
      cmd_byte = (i == 0) ? op : (i < 5) ? a[(4-i)*8 +: 8] : 8'h00;
    end
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic go(input logic [2:0] blk, input int dly, input bit f, input bit st,
                    input bit arm, input string tag);
    @(negedge clk);
    ctl_we = 1; ctl_start = st; ctl_blk = blk; ctl_delay = DW'(dly); ctl_fast = f;
    fast_cur = f;
    t_ref = cyc + 1;
    exp_gap = (dly + 12) * unit_clk(f);
    gap_tag = tag;
    gap_on = arm;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic wait_done;
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  task automatic run_read(input logic [31:0] a, input logic [2:0] blk, input int dly,
                          input bit f, input string tag);
    logic [31:0] eff;
    int n;
    eff = (a < 32'h8000) ? (32'h8000 | (a & 32'h1FF)) : a;
    n = (256 << blk) / 4;
    irq_cnt = 0; dma_cnt = 0; words = 0;
    exp_q.delete();
    for (int i = 0; i < n; i++) exp_q.push_back(pat(eff + 32'(4 * i)));
    data_tag = tag;
    put_cmd(8'hB7, a);
    go(blk, dly, f, 1, 1, "R4 first gap");
    wait_done();
    check(words == n, "R3 word count", words, n);
    check(irq_cnt == (irq_en ? 1 : 0), "R8 irq count", irq_cnt, irq_en ? 1 : 0);
    check(dma_cnt == (dma_en ? n : 0), "R13 dma count", dma_cnt, dma_en ? n : 0);
    check(!busy, "R7 busy end", busy, 0);
  endtask

  task automatic no_fetch(input logic [7:0] op, input logic [2:0] blk, input string tag);
    int r0;
    r0 = req_cnt;
    exp_q.delete();
    put_cmd(op, 32'h0002_0000);
    go(blk, 0, 0, 1, 0, tag);
    repeat (300) @(negedge clk);
    check(busy, tag, busy, 1);
    check(!word_ready, tag, word_ready, 0);
    check(req_cnt == r0, tag, req_cnt, r0);
    go(blk, 0, 0, 0, 0, tag);
    check(!busy, tag, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !word_ready && !irq && !rom_req, "R7 reset", {busy, word_ready, irq, rom_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R5 R8 R13: 5-clock byte-time, irq and dma on
    irq_en = 1; dma_en = 1; slow_owner = 0;
    run_read(32'h0002_0000, 3'd1, 3, 0, "R1 data");
    // R3 R5: 8-clock byte-time, larger block, no irq/dma
    irq_en = 0; dma_en = 0;
    run_read(32'h0001_0F00, 3'd2, 0, 1, "R1 data blk2");
    // R2 R5: redirect, doubled byte-time
    irq_en = 1; slow_owner = 1;
    run_read(32'h0000_7FFC, 3'd1, 1, 0, "R2 redirect data");

    // R9 identifier
    begin
      int r0;
      r0 = req_cnt;
      slow_owner = 0;
      exp_q.delete();
      exp_q.push_back(ID);
      data_tag = "R9 id";
      put_cmd(8'hB8, 32'h0);
      go(3'd0, 0, 0, 1, 0, "R9");
      check(word_ready && busy, "R9 ready at once", {word_ready, busy}, 2'b11);
      wait_done();
      check(req_cnt == r0, "R9 no fetch", req_cnt, r0);
      check(!busy, "R9 busy end", busy, 0);
    end

    no_fetch(8'h9F, 3'd1, "R11 other cmd");
    no_fetch(8'hB7, 3'd0, "R3 zero block");
    no_fetch(8'hB7, 3'd7, "R3 field7");

    // R10 serial mode ignores start
    begin
      int r0;
      r0 = req_cnt;
      spi_mode = 1;
      put_cmd(8'hB7, 32'h0002_0000);
      go(3'd1, 0, 0, 1, 0, "R10");
      repeat (300) @(negedge clk);
      check(!busy, "R10 busy", busy, 0);
      check(req_cnt == r0, "R10 no fetch", req_cnt, r0);
      spi_mode = 0;
    end

    // R12 restart reloads timer
    begin
      int n;
      n = 128;
      irq_en = 1; dma_en = 0; slow_owner = 1;
      irq_cnt = 0; dma_cnt = 0; words = 0;
      exp_q.delete();
      for (int i = 0; i < n; i++) exp_q.push_back(pat(32'h0004_0000 + 32'(4 * i)));
      data_tag = "R12 data";
      put_cmd(8'hB7, 32'h0004_0000);
      go(3'd1, 20, 0, 1, 1, "R12 old");
      repeat (100) @(negedge clk);
      go(3'd1, 0, 1, 1, 1, "R12 restart gap");
      wait_done();
      check(words == n, "R12 words", words, n);
      check(irq_cnt == 1, "R8 irq restart", irq_cnt, 1);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule